// File: doc/BRIEF.md
# NAND Flash Bus Interface Controller

This block sits between a simple register port and an 8-bit NAND flash bus shared by two devices. Software selects a device through a control register, then writes bytes to one of three port addresses. The port address picks the bus cycle type: the command port raises CLE, the address port raises ALE, and the data port leaves both low. Each write becomes one write-enable strobe. A read of the data port produces one read-enable strobe, and the byte sampled from the bus is returned on the read channel. The control register also holds the controller enable bit and the write-protect bit. The device's ready/busy line is synchronized and can be read from a status register.

Bus cycles come from a small state machine with the states `ST_IDLE`, `ST_WR_LO`, `ST_WR_HI`, `ST_RD_LO` and `ST_RD_HI`. An accepted write moves IDLE to WR_LO. WR_LO moves to WR_HI after `STROBE` clocks. WR_HI returns to IDLE after another `STROBE` clocks. An accepted data read takes the same path through RD_LO and RD_HI. In the RD_LO to RD_HI transition the bus byte is captured and the read response is issued. Every state other than IDLE reports busy.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset the control register reads 0x0E: controller disabled, both chip enables high (deselected) and write protect active (`nand_wp_n`=0). CLE and ALE are low, WE# and RE# are high, and `busy` is 0.
- R2: Control bit 1 drives `nand_ce_n[0]` and bit 2 drives `nand_ce_n[1]`, with no inversion, so 0 selects a device. Writing 1 to both bits in one write deselects both devices. Control writes are accepted at any time.
- R3: A write to address 1 (command port) drives the byte on `nand_dq_out` with `nand_dq_oe`=1, CLE=1 and ALE=0. WE# is low for STROBE clocks and then high for STROBE clocks.
- R4: A write to address 2 (address port) makes the same cycle as R3, but with ALE=1 and CLE=0.
- R5: A write to address 3 (data port) makes the same cycle as R3, but with CLE=0 and ALE=0.
- R6: `busy` is 1 for exactly 2×STROBE clocks after a bus access is accepted. Port writes and reads issued while `busy` is 1 are ignored.
- R7: A read of address 3 drives RE# low for STROBE clocks with `nand_dq_oe`=0, then high for STROBE clocks. The bus is sampled at the end of the low phase, and `reg_rvalid` pulses for one cycle with that byte on `reg_rdata`.
- R8: A read of address 4 returns `nand_rb` on bit 0 (1 = ready), after it has passed through a two-flop synchronizer. The response comes the cycle after the read is accepted.
- R9: While control bit 0 (enable) is 0, writes and reads to the command, address and data ports are ignored, and CLE, ALE, WE# and RE# stay inactive.
- R10: Control bit 3 is write protect: 1 drives `nand_wp_n` low, 0 drives it high.
- R11: A read of address 0 returns control bits [3:0] on `reg_rdata[3:0]` with the upper bits 0, one cycle after the read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 command, 2 address, 3 data, 4 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| reg_rvalid | output | 1 | Read data valid pulse |
| busy | output | 1 | Bus cycle in progress |
| nand_ce_n | output | 2 | Active-low chip enables, one per device |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_dq_out | output | 8 | Bus data driven to the flash |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data from the flash |
| nand_rb | input | 1 | Ready/busy from the flash, 1 = ready |

## Verification
The assertions check several rules on every cycle:
- CLE and ALE are never high together.
- WE# and RE# are never low together.
- The bus is driven whenever WE# is low and released whenever RE# is low.
- Both strobes stay inactive while the controller is idle or disabled.

Some behaviour needs the bench's scenarios. These are the exact low and high phase lengths, the latch levels for each port, that a second access made while busy is dropped, the byte captured at the end of the read low phase, and the two-cycle delay from the ready/busy pin to the status bit.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LO,
        ST_WR_HI,
        ST_RD_LO,
        ST_RD_HI
    } bus_state_e;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_CMD  = 3'd1;
    localparam logic [2:0] ADR_ADR  = 3'd2;
    localparam logic [2:0] ADR_DAT  = 3'd3;
    localparam logic [2:0] ADR_STAT = 3'd4;

    localparam int CTRL_W = 4;
    localparam logic [CTRL_W-1:0] CTRL_RST = 4'b1110;
endpackage

// File: rtl/nbc_sync.sv
module nbc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/nbc_regs.sv
module nbc_regs
    import nbc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              rd_ctrl,
    input  logic              rd_stat,
    input  logic              rb_sync,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              rvalid,
    output logic [DW-1:0]     rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else if (wr_ctrl) ctrl_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_ctrl | rd_stat;
            if (rd_ctrl)      rdata <= DW'(ctrl_q);
            else if (rd_stat) rdata <= DW'(rb_sync);
        end
    end
endmodule

// File: rtl/nbc_bus_fsm.sv
module nbc_bus_fsm
    import nbc_pkg::*;
#(
    parameter int DW     = 8,
    parameter int STROBE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_wr,
    input  logic          start_rd,
    input  logic          wr_cle,
    input  logic          wr_ale,
    input  logic [DW-1:0] wr_byte,
    input  logic          bus_en,
    input  logic [DW-1:0] dq_in,
    output logic          busy,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          rd_valid,
    output logic [DW-1:0] rd_byte
);
    localparam int CW = (STROBE > 1) ? $clog2(STROBE) : 1;
    localparam logic [CW-1:0] LAST = CW'(STROBE - 1);

    bus_state_e    state, state_nx;
    logic [CW-1:0] cnt;
    logic          lat_cle, lat_ale;
    logic [DW-1:0] lat_byte;
    logic          phase_end;

    assign phase_end = (cnt == LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_wr)      state_nx = ST_WR_LO;
                else if (start_rd) state_nx = ST_RD_LO;
            end
            ST_WR_LO: if (phase_end) state_nx = ST_WR_HI;
            ST_WR_HI: if (phase_end) state_nx = ST_IDLE;
            ST_RD_LO: if (phase_end) state_nx = ST_RD_HI;
            ST_RD_HI: if (phase_end) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            lat_cle  <= 1'b0;
            lat_ale  <= 1'b0;
            lat_byte <= '0;
            rd_valid <= 1'b0;
            rd_byte  <= '0;
        end else begin
            state    <= state_nx;
            rd_valid <= 1'b0;
            if (state == ST_IDLE) begin
                cnt <= '0;
                if (start_wr) begin
                    lat_cle  <= wr_cle;
                    lat_ale  <= wr_ale;
                    lat_byte <= wr_byte;
                end
            end else if (phase_end) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (state == ST_RD_LO && phase_end) begin
                rd_byte  <= dq_in;
                rd_valid <= 1'b1;
            end
        end
    end

    always_comb begin
        busy   = 1'b1;
        cle    = 1'b0;
        ale    = 1'b0;
        we_n   = 1'b1;
        re_n   = 1'b1;
        dq_oe  = 1'b0;
        dq_out = lat_byte;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_WR_LO: begin
                cle = lat_cle & bus_en; ale = lat_ale & bus_en;
                we_n = ~bus_en; dq_oe = bus_en;
            end
            ST_WR_HI: begin
                cle = lat_cle & bus_en; ale = lat_ale & bus_en;
                dq_oe = bus_en;
            end
            ST_RD_LO: re_n = ~bus_en;
            ST_RD_HI: re_n = 1'b1;
            default:  busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
    import nbc_pkg::*;
#(
    parameter int DW          = 8,
    parameter int STROBE      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          reg_rvalid,
    output logic          busy,
    output logic [1:0]    nand_ce_n,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_re_n,
    output logic          nand_wp_n,
    output logic [DW-1:0] nand_dq_out,
    output logic          nand_dq_oe,
    input  logic [DW-1:0] nand_dq_in,
    input  logic          nand_rb
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              rb_sync;
    logic              acc_bus, is_port, start_wr, start_rd;
    logic              rd_ctrl, rd_stat;
    logic              regs_rv, fsm_rv;
    logic [DW-1:0]     regs_rd, fsm_rd;

    assign acc_bus  = ~busy & ctrl_q[0];
    assign is_port  = (reg_addr == ADR_CMD) || (reg_addr == ADR_ADR) || (reg_addr == ADR_DAT);
    assign start_wr = reg_wr & acc_bus & is_port;
    assign start_rd = reg_rd & acc_bus & (reg_addr == ADR_DAT);
    assign rd_ctrl  = reg_rd & ~busy & (reg_addr == ADR_CTRL);
    assign rd_stat  = reg_rd & ~busy & (reg_addr == ADR_STAT);

    nbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(nand_rb), .q(rb_sync)
    );

    nbc_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(reg_wr & (reg_addr == ADR_CTRL)),
        .wdata(reg_wdata[CTRL_W-1:0]),
        .rd_ctrl(rd_ctrl), .rd_stat(rd_stat), .rb_sync(rb_sync),
        .ctrl_q(ctrl_q), .rvalid(regs_rv), .rdata(regs_rd)
    );

    nbc_bus_fsm #(.DW(DW), .STROBE(STROBE)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_wr(start_wr), .start_rd(start_rd),
        .wr_cle(reg_addr == ADR_CMD), .wr_ale(reg_addr == ADR_ADR),
        .wr_byte(reg_wdata), .bus_en(ctrl_q[0]), .dq_in(nand_dq_in),
        .busy(busy), .cle(nand_cle), .ale(nand_ale),
        .we_n(nand_we_n), .re_n(nand_re_n),
        .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
        .rd_valid(fsm_rv), .rd_byte(fsm_rd)
    );

    assign nand_ce_n  = ctrl_q[2:1];
    assign nand_wp_n  = ~ctrl_q[3];
    assign reg_rvalid = regs_rv | fsm_rv;
    assign reg_rdata  = fsm_rv ? fsm_rd : regs_rd;
endmodule

// File: rtl/nbc_checker.sv
module nbc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ctrl,
    input logic       busy,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic       re_n,
    input logic       dq_oe
);
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |-> (we_n && re_n && !cle && !ale));

    p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (we_n && re_n && !dq_oe));

    p_we_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe);

    p_re_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);
endmodule

bind nand_bus_ctrl nbc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .busy(busy),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .dq_oe(nand_dq_oe)
);

// File: tb/sim_nand_bus_ctrl.sv
`timescale 1ns/1ps
module sim_nand_bus_ctrl;
    localparam int S = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       reg_rvalid, busy;
    logic [1:0] nand_ce_n;
    logic       nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_dq_oe;
    logic [7:0] nand_dq_out;
    logic [7:0] nand_dq_in = '0;
    logic       nand_rb = 1'b0;

    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    nand_bus_ctrl #(.STROBE(S)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .busy(busy), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    // {addr[2:0], data[7:0], cle, ale}
    localparam logic [12:0] VEC [6] = '{
        {3'd1, 8'hFF, 1'b1, 1'b0},
        {3'd2, 8'h00, 1'b0, 1'b1},
        {3'd3, 8'hA5, 1'b0, 1'b0},
        {3'd1, 8'h30, 1'b1, 1'b0},
        {3'd2, 8'h5A, 1'b0, 1'b1},
        {3'd3, 8'h3C, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one access at a negedge; returns at the negedge after the accepting edge.
    task automatic issue(input logic wr, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = wr; reg_rd = ~wr; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic bus_write(input string req, input logic [2:0] a, input logic [7:0] d,
                             input logic ecle, input logic eale);
        issue(1'b1, a, d);
        for (int k = 0; k < 2*S; k++) begin
            chk(req, {busy, nand_we_n, nand_cle, nand_ale, nand_dq_oe, nand_dq_out},
                {1'b1, (k >= S), ecle, eale, 1'b1, d});
            @(negedge clk);
        end
        chk(req, {busy, nand_we_n, nand_re_n}, 3'b011);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {nand_ce_n, nand_wp_n, nand_cle, nand_ale, nand_we_n, nand_re_n, busy},
            {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0});
        issue(1'b0, 3'd0, 8'h00);
        chk("R1 R11 ctrl readback", {reg_rvalid, reg_rdata}, {1'b1, 8'h0E});

        // R9 disabled: command write ignored
        issue(1'b1, 3'd1, 8'h70);
        chk("R9", {busy, nand_we_n, nand_cle}, 3'b010);
        issue(1'b0, 3'd3, 8'h00);
        chk("R9 read ignored", {busy, nand_re_n, reg_rvalid}, 3'b010);

        // enable, select both, unprotect
        issue(1'b1, 3'd0, 8'h01);
        chk("R2 R10", {nand_ce_n, nand_wp_n}, {2'b00, 1'b1});
        issue(1'b0, 3'd0, 8'h00);
        chk("R11", {reg_rvalid, reg_rdata}, {1'b1, 8'h01});
        issue(1'b1, 3'd0, 8'h03);
        chk("R2 chip1 only", nand_ce_n, 2'b01);
        issue(1'b1, 3'd0, 8'h05);
        chk("R2 chip0 only", nand_ce_n, 2'b10);

        // R3 R4 R5 table walk
        for (int i = 0; i < 6; i++) begin
            bus_write((VEC[i][12:10] == 3'd1) ? "R3" : (VEC[i][12:10] == 3'd2) ? "R4" : "R5",
                      VEC[i][12:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R6 second write during busy is dropped
        issue(1'b1, 3'd1, 8'h11);
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h22;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R6 first still cmd", {nand_cle, nand_ale, nand_dq_out}, {1'b1, 1'b0, 8'h11});
        for (int k = 1; k < 2*S; k++) @(negedge clk);
        chk("R6 busy ends", {busy, nand_we_n}, 2'b01);
        @(negedge clk);
        chk("R6 no second cycle", {busy, nand_we_n, nand_ale}, 3'b010);

        // R7 data read
        nand_dq_in = 8'hC3;
        issue(1'b0, 3'd3, 8'h00);
        for (int k = 0; k < S; k++) begin
            chk("R7 low phase", {busy, nand_re_n, nand_dq_oe, nand_we_n}, 4'b1001);
            if (k == S-1) nand_dq_in = 8'hC3;
            @(negedge clk);
        end
        nand_dq_in = 8'h00;
        chk("R7 capture", {reg_rvalid, reg_rdata, nand_re_n}, {1'b1, 8'hC3, 1'b1});
        for (int k = S; k < 2*S; k++) @(negedge clk);
        chk("R7 end", {busy, reg_rvalid}, 2'b00);

        // R8 synchronizer latency
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        nand_rb = 1'b1;
        reg_rd = 1'b1; reg_addr = 3'd4;
        @(negedge clk);
        chk("R8 lat1", {reg_rvalid, reg_rdata}, {1'b1, 8'h00});
        @(negedge clk);
        chk("R8 lat2", {reg_rvalid, reg_rdata}, {1'b1, 8'h00});
        @(negedge clk);
        chk("R8 ready", {reg_rvalid, reg_rdata}, {1'b1, 8'h01});
        reg_rd = 1'b0;

        // R2 deselect all, R10 protect, R9 disable again
        issue(1'b1, 3'd0, 8'h0E);
        chk("R2 deselect all", {nand_ce_n, nand_wp_n}, {2'b11, 1'b0});
        issue(1'b1, 3'd3, 8'h99);
        chk("R9 disabled data write", {busy, nand_we_n}, 2'b01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule